// File: doc/BRIEF.md
# Vendor Command Memory Access Decoder

This block sits between a storage-command front end and a 64 KB byte-addressed on-chip memory. It takes a vendor-specific command descriptor block (CDB) of up to twelve bytes through a valid/ready handshake and turns it into memory activity. There are three commands: a bulk read that streams up to 255 bytes back to the host side, a one-byte store whose value rides inside the descriptor itself, and a reset request that raises a one-cycle pulse on one of two reset request outputs.

Because the write value sits inside the descriptor, a store never needs a data-out phase. Each store commits exactly one byte and completes at once. Every command ends with a one-cycle `done` pulse. `err` is high alongside it when the descriptor was rejected. A rejected descriptor leaves memory untouched and raises no reset pulse.

Reads are fetched from the memory one cycle ahead and are presented straight from the memory output. A host that keeps `rd_ready` high receives one byte per cycle. Regions of the address map that the memory marks as unmapped read back as zero.

Top module: `vcmd_mem_decoder`

## Requirements
- R1: While and right after a synchronous reset (`rst_n` low), `cmd_ready` is 1 and `rd_valid`, `rd_last`, `done`, `err`, `mem_en`, `mem_we`, `req_cpu_rst` and `req_link_rst` are all 0.
- R2: CDB byte k occupies `cmd_cdb[8k+7:8k]`. Opcode 0xE4 in byte 0 reads N = byte 1 bytes, starting at address (byte 3 << 8) | byte 4. Successive bytes come from increasing addresses. `rd_last` is high on the Nth byte only. `done` pulses with `err` = 0 in the cycle after the last byte is accepted.
- R3: A byte fetched while the memory reports `mem_hit` = 0 (unmapped) is delivered as 0x00.
- R4: A read whose address passes 0xFFFF continues at 0x0000.
- R5: While `rd_valid` is high and `rd_ready` is low, `rd_byte` and `rd_valid` hold and no new memory access is issued. With `rd_ready` held high, bytes arrive one per cycle.
- R6: Opcode 0xE5 performs exactly one memory write cycle of byte 1 to address (byte 3 << 8) | byte 4. It streams no read data, and `done` follows with `err` = 0.
- R7: Opcode 0xE8 with byte 1 = 0x00 pulses `req_cpu_rst` for one cycle. With byte 1 = 0x01 it pulses `req_link_rst` for one cycle. In both cases `done` pulses in the same cycle with `err` = 0 and no memory access takes place.
- R8: Opcode 0xE8 with any other byte 1 completes with `err` = 1 and raises no reset pulse.
- R9: A read with length 0 completes with `err` = 1, makes no memory access and delivers no data.
- R10: Any opcode other than 0xE4, 0xE5 or 0xE8 completes with `err` = 1 and makes no memory access.
- R11: Padding bytes (byte 2 and bytes 5 to 11 for reads and writes, bytes 2 to 11 for resets) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Descriptor offered |
| cmd_ready | output | 1 | Block idle, descriptor taken this cycle if valid |
| cmd_cdb | input | 96 | Descriptor, byte k at bits 8k+7:8k |
| rd_valid | output | 1 | Read byte presented |
| rd_ready | input | 1 | Host takes the read byte |
| rd_byte | output | 8 | Read data |
| rd_last | output | 1 | Final byte of the read |
| done | output | 1 | One-cycle command completion pulse |
| err | output | 1 | Rejected descriptor, valid with done |
| req_cpu_rst | output | 1 | One-cycle processor reset request |
| req_link_rst | output | 1 | One-cycle link soft-reset request |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after a read, held until the next access |
| mem_hit | input | 1 | Address of the last read was mapped, same timing as mem_rdata |

## Verification
A wrong address counter shows on the first or second streamed byte as a value that does not match the address pattern. A counter that fails to wrap shows in the byte after 0xFFFF. A stale pending or remaining-count register shows within one cycle of a stall as a changed `rd_byte`, a fetch issued during the stall, a missing or extra `rd_last`, or a `done` pulse that does not land exactly one cycle after the final handshake. A bad decode shows in the same cycle as the completion pulse: a wrong `err` value, a reset pulse on the wrong output, or a memory cycle where none is allowed.

// File: rtl/vcmd_pkg.sv
// Package: shared opcodes and command classes for the vendor command decoder.
// Assumes descriptors are byte-indexed with byte 0 in the least significant bits.
package vcmd_pkg;

    localparam logic [7:0] OPC_XREAD  = 8'hE4;
    localparam logic [7:0] OPC_XWRITE = 8'hE5;
    localparam logic [7:0] OPC_XRESET = 8'hE8;

    localparam logic [7:0] RSTSEL_CPU  = 8'h00;
    localparam logic [7:0] RSTSEL_LINK = 8'h01;

    typedef enum logic [2:0] {
        K_READ,
        K_WRITE,
        K_RST_CPU,
        K_RST_LINK,
        K_BAD
    } cmd_kind_t;

endpackage

// File: rtl/vcmd_cdb_parse.sv
// Module: combinational descriptor classifier.
// Extracts opcode, length/value, address and rejects malformed descriptors.
// Assumes CDB_BYTES >= 6; padding bytes are deliberately ignored.
module vcmd_cdb_parse
    import vcmd_pkg::*;
#(
    parameter int CDB_BYTES = 12,
    parameter int ADDR_W    = 16
) (
    input  logic [8*CDB_BYTES-1:0] cdb,
    output cmd_kind_t              kind,
    output logic [ADDR_W-1:0]      addr,
    output logic [7:0]             arg
);
    localparam int CDB_W = 8 * CDB_BYTES;

    logic [7:0]  opc;
    logic [15:0] full_addr;
    logic        unused_pad;

    assign opc       = cdb[7:0];
    assign arg       = cdb[15:8];
    assign full_addr = {cdb[31:24], cdb[39:32]};
    assign addr      = full_addr[ADDR_W-1:0];
    assign unused_pad = ^{cdb[CDB_W-1:40], cdb[23:16]};

    // Classify the opcode and check its argument byte.
    always_comb begin
        kind = K_BAD;
        unique case (opc)
            OPC_XREAD:  kind = (arg != 8'h00) ? K_READ : K_BAD;
            OPC_XWRITE: kind = K_WRITE;
            OPC_XRESET: begin
                if (arg == RSTSEL_CPU)       kind = K_RST_CPU;
                else if (arg == RSTSEL_LINK) kind = K_RST_LINK;
                else                         kind = K_BAD;
            end
            default:    kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/vcmd_rd_stream.sv
// Module: read streamer.
// Issues one memory read per cycle while the host accepts data, and presents
// the memory output directly as the stream byte (zero when unmapped).
// Assumes the memory returns data one cycle after mem_en and holds it while idle.
module vcmd_rd_stream #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_len,
    input  logic              rd_ready,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_hit,
    output logic              fetch,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic              rd_last,
    output logic              finish
);
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        remain_q;
    logic              pend_q;
    logic              last_q;

    assign fetch      = (remain_q != 8'd0) && (!pend_q || rd_ready);
    assign fetch_addr = addr_q;
    assign rd_valid   = pend_q;
    assign rd_byte    = (pend_q && mem_hit) ? mem_rdata : 8'h00;
    assign rd_last    = pend_q && last_q;
    assign finish     = rd_last && rd_ready;

    // Advance address and count on each fetch; track the byte on display.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= 8'd0;
            pend_q   <= 1'b0;
            last_q   <= 1'b0;
        end else if (start) begin
            addr_q   <= start_addr;
            remain_q <= start_len;
            pend_q   <= 1'b0;
            last_q   <= 1'b0;
        end else if (fetch) begin
            addr_q   <= addr_q + 1'b1;
            remain_q <= remain_q - 8'd1;
            pend_q   <= 1'b1;
            last_q   <= (remain_q == 8'd1);
        end else if (pend_q && rd_ready) begin
            pend_q   <= 1'b0;
            last_q   <= 1'b0;
        end
    end

    AST_STALL_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |-> !fetch);                       // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> rd_valid);                     // R5
    AST_LAST_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        rd_last |-> rd_valid);                                     // R2
endmodule

// File: rtl/vcmd_mem_decoder.sv
// Module: top of the vendor command memory access decoder.
// Accepts a descriptor when idle, runs a read stream, a single-byte write or
// a reset request, and ends every command with a one-cycle done pulse.
// Assumes a single-port byte memory with one-cycle read latency.
module vcmd_mem_decoder
    import vcmd_pkg::*;
#(
    parameter int CDB_BYTES = 12,
    parameter int ADDR_W    = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [8*CDB_BYTES-1:0] cmd_cdb,
    output logic                   rd_valid,
    input  logic                   rd_ready,
    output logic [7:0]             rd_byte,
    output logic                   rd_last,
    output logic                   done,
    output logic                   err,
    output logic                   req_cpu_rst,
    output logic                   req_link_rst,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic [7:0]             mem_rdata,
    input  logic                   mem_hit
);
    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_t;

    state_t            state_q;
    cmd_kind_t         kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [7:0]        cmd_arg;
    logic              accept;
    logic              rd_start;
    logic              st_fetch;
    logic [ADDR_W-1:0] st_addr;
    logic              st_finish;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [7:0]        wr_val_q;
    logic              done_q, err_q, cpu_q, link_q;

    vcmd_cdb_parse #(.CDB_BYTES(CDB_BYTES), .ADDR_W(ADDR_W)) i_parse (
        .cdb  (cmd_cdb),
        .kind (kind),
        .addr (cmd_addr),
        .arg  (cmd_arg)
    );

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign rd_start  = accept && (kind == K_READ);

    vcmd_rd_stream #(.ADDR_W(ADDR_W)) i_stream (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (rd_start),
        .start_addr (cmd_addr),
        .start_len  (cmd_arg),
        .rd_ready   (rd_ready),
        .mem_rdata  (mem_rdata),
        .mem_hit    (mem_hit),
        .fetch      (st_fetch),
        .fetch_addr (st_addr),
        .rd_valid   (rd_valid),
        .rd_byte    (rd_byte),
        .rd_last    (rd_last),
        .finish     (st_finish)
    );

    // Steer the single memory port to the write or to the read streamer.
    always_comb begin
        mem_we    = (state_q == ST_WRITE);
        mem_en    = st_fetch || mem_we;
        mem_addr  = mem_we ? wr_addr_q : st_addr;
        mem_wdata = wr_val_q;
    end

    // Command sequencing and one-cycle completion / reset request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wr_addr_q <= '0;
            wr_val_q  <= 8'h00;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            cpu_q     <= 1'b0;
            link_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            cpu_q  <= 1'b0;
            link_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    unique case (kind)
                        K_READ:     state_q <= ST_READ;
                        K_WRITE: begin
                            state_q   <= ST_WRITE;
                            wr_addr_q <= cmd_addr;
                            wr_val_q  <= cmd_arg;
                        end
                        K_RST_CPU:  begin cpu_q  <= 1'b1; done_q <= 1'b1; end
                        K_RST_LINK: begin link_q <= 1'b1; done_q <= 1'b1; end
                        default:    begin err_q  <= 1'b1; done_q <= 1'b1; end
                    endcase
                end
                ST_READ: if (st_finish) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                ST_WRITE: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign done         = done_q;
    assign err          = err_q;
    assign req_cpu_rst  = cpu_q;
    assign req_link_rst = link_q;

    AST_RST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_cpu_rst, req_link_rst}));                    // R7
    AST_CPU_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_cpu_rst |=> !req_cpu_rst);                             // R7
    AST_LINK_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_link_rst |=> !req_link_rst);                           // R7
    AST_WRITE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |=> !(mem_en && mem_we));               // R6
    AST_BAD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && kind == K_BAD) |=> !mem_en);                    // R10
    AST_ERR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !(req_cpu_rst || req_link_rst));                   // R8
    AST_IDLE_NO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !rd_valid);                                  // R2
endmodule

// File: tb/test_vcmd_mem_decoder.sv
module test_vcmd_mem_decoder;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [95:0] cmd_cdb = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_byte;
    logic        rd_last;
    logic        done, err, req_cpu_rst, req_link_rst;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_hit = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    vcmd_mem_decoder i_vcmd_mem_decoder (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_cdb(cmd_cdb), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_byte(rd_byte), .rd_last(rd_last), .done(done), .err(err),
        .req_cpu_rst(req_cpu_rst), .req_link_rst(req_link_rst),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_hit(mem_hit)
    );

    // Memory model: pattern content, 0x3000-0x3FFF unmapped, output held when idle.
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction
    function automatic logic [7:0] expect_byte(input logic [15:0] a);
        return (a[15:12] == 4'h3) ? 8'h00 : pat(a);
    endfunction
    always @(posedge clk) begin
        if (mem_en && !mem_we) begin
            mem_rdata <= pat(mem_addr);
            mem_hit   <= (mem_addr[15:12] != 4'h3);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    function automatic logic [95:0] mk_cdb(input logic [7:0] op, b1, hi, lo, pad);
        logic [95:0] c = {12{pad}};
        c[7:0]   = op;
        c[15:8]  = b1;
        c[31:24] = hi;
        c[39:32] = lo;
        return c;
    endfunction

    task automatic check_idle_state(input string tag);
        check(cmd_ready == 1'b1, {tag, " cmd_ready"}, cmd_ready, 1);
        check({rd_valid, rd_last, done, err} == 4'b0, {tag, " stream/done"},
              {rd_valid, rd_last, done, err}, 0);
        check({mem_en, mem_we, req_cpu_rst, req_link_rst} == 4'b0, {tag, " mem/pulses"},
              {mem_en, mem_we, req_cpu_rst, req_link_rst}, 0);
    endtask

    task automatic run_cmd(input logic [95:0] cdb, input bit stall, input int exp_n,
                           input logic [15:0] base, input bit exp_err, input bit exp_cpu,
                           input bit exp_link, input bit exp_wr,
                           input logic [7:0] wv, input string tag);
        int n = 0, wr = 0, en = 0, cpu = 0, lnk = 0, cyc = 0, last_hs = -10, done_cyc = -1;
        bit got_done = 0, held = 0, err_s = 0;
        logic [7:0] held_b = 8'h00;
        logic [15:0] wa_s = 16'h0;
        logic [7:0] wd_s = 8'h0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_cdb   = cdb;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_cdb   = '1;
        while (!got_done && cyc < 3000) begin
            rd_ready = stall ? ((cyc % 3) != 2) : 1'b1;
            #1;
            if (mem_en) en++;
            if (mem_en && mem_we) begin wr++; wa_s = mem_addr; wd_s = mem_wdata; end
            if (req_cpu_rst) cpu++;
            if (req_link_rst) lnk++;
            if (held) begin
                check(rd_valid && rd_byte == held_b, {tag, " R5 hold"}, rd_byte, held_b);
            end
            if (rd_valid && !rd_ready) begin
                check(!mem_en, {tag, " R5 no fetch in stall"}, mem_en, 0);
            end
            held = rd_valid && !rd_ready;
            held_b = rd_byte;
            if (rd_valid && rd_ready) begin
                logic [15:0] a = base + 16'(n);
                check(rd_byte == expect_byte(a), {tag, " R2/R3/R4 data"}, rd_byte, expect_byte(a));
                check(rd_last == (n == exp_n - 1), {tag, " R2 last"}, rd_last, (n == exp_n - 1));
                n++;
                last_hs = cyc;
            end
            if (done) begin got_done = 1; err_s = err; done_cyc = cyc; end
            else begin @(negedge clk); cyc++; end
        end
        check(got_done, {tag, " done seen"}, got_done, 1);
        check(err_s == exp_err, {tag, " R8/R9/R10 err flag"}, err_s, exp_err);
        check(n == exp_n, {tag, " R2 byte count"}, n, exp_n);
        check(cpu == int'(exp_cpu) && lnk == int'(exp_link), {tag, " R7 reset pulses"},
              {cpu[7:0], lnk[7:0]}, {8'(exp_cpu), 8'(exp_link)});
        check(wr == int'(exp_wr), {tag, " R6 write count"}, wr, exp_wr);
        if (exp_wr) begin
            check(wa_s == base && wd_s == wv, {tag, " R6 write addr/data"},
                  {wa_s, wd_s}, {base, wv});
        end
        if (exp_err || exp_cpu || exp_link) begin
            check(en == 0, {tag, " R9/R10 no memory access"}, en, 0);
        end
        if (exp_n > 0) begin
            check(done_cyc - last_hs == 1, {tag, " R2 done timing"}, done_cyc - last_hs, 1);
        end
        @(negedge clk);
        #1;
        check(!done && !req_cpu_rst && !req_link_rst, {tag, " R7 one-cycle pulses"},
              {done, req_cpu_rst, req_link_rst}, 0);
    endtask

    // Vector: op, byte1, addr hi, addr lo, pad, stall, -, exp_err, exp_cpu, exp_link
    localparam logic [63:0] VEC [12] = '{
        {8'hE4, 8'd4,   8'h00, 8'h10, 8'h00, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE4, 8'd8,   8'h12, 8'h34, 8'hA5, 1'b1, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE5, 8'h3C,  8'h20, 8'h00, 8'hFF, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE8, 8'h00,  8'h77, 8'h77, 8'h77, 1'b0, 20'h0, 1'b0, 1'b1, 1'b0},
        {8'hE8, 8'h01,  8'hC3, 8'hC3, 8'hC3, 1'b0, 20'h0, 1'b0, 1'b0, 1'b1},
        {8'hE8, 8'h02,  8'h00, 8'h00, 8'h00, 1'b0, 20'h0, 1'b1, 1'b0, 1'b0},
        {8'hE4, 8'd0,   8'h01, 8'h00, 8'h00, 1'b0, 20'h0, 1'b1, 1'b0, 1'b0},
        {8'h12, 8'd4,   8'h01, 8'h00, 8'h00, 1'b0, 20'h0, 1'b1, 1'b0, 1'b0},
        {8'hE4, 8'd6,   8'h2F, 8'hFD, 8'h00, 1'b1, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE4, 8'd5,   8'hFF, 8'hFD, 8'h5C, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE5, 8'h00,  8'hFF, 8'hFF, 8'h11, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0},
        {8'hE4, 8'd255, 8'h80, 8'h00, 8'hEE, 1'b1, 20'h0, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check_idle_state("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle_state("R1 after reset");

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 (padding varies per entry)
        for (int i = 0; i < 12; i++) begin
            logic [63:0] v = VEC[i];
            logic [7:0]  op = v[63:56];
            logic [7:0]  b1 = v[55:48];
            bit          e_err = v[2];
            int          n_exp = (op == 8'hE4 && !e_err) ? int'(b1) : 0;
            run_cmd(mk_cdb(op, b1, v[47:40], v[39:32], v[31:24]), v[23], n_exp,
                    {v[47:40], v[39:32]}, e_err, v[1], v[0], op == 8'hE5, b1,
                    $sformatf("vec%0d R11", i));
        end

        // Directed: reset in the middle of a read stream returns to the R1 state.
        @(negedge clk);
        rd_ready  = 1'b1;
        cmd_valid = 1'b1;
        cmd_cdb   = mk_cdb(8'hE4, 8'd20, 8'h01, 8'h00, 8'h00);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(rd_valid, "R2 stream active before reset", rd_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check_idle_state("R1 mid-stream reset");
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check_idle_state("R1 after mid-stream reset");

        // Directed: a fresh read after the interrupted one behaves normally.
        run_cmd(mk_cdb(8'hE4, 8'd3, 8'h45, 8'h67, 8'h00), 1'b0, 3, 16'h4567,
                1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "post-reset R2");

        summary();
    end
endmodule